// File: doc/BRIEF.md
# Serial Output Freeze Controller

This block sits between a clock generator's twelve gateable output clocks and their pins and lets a host stop or restart each one through a two-wire serial link. A free-running serial clock samples a serial data line. While idle, the receiver watches the line for a low start bit. It then collects twelve enable bits, one per serial clock period, and writes them into the enable register as one word. A 1 lets the corresponding clock run. A 0 freezes that clock at logic 0.

Each enable bit crosses into the clock domain of the output it controls through a short synchroniser. It is then taken up on a falling edge of that clock, so the gate only opens or closes while the clock is low. A gated output therefore never shows a shortened high pulse. Two outputs are exempt and pass straight through: bank C output 0 and the feedback output. This means a corrupted frame can never stop the feedback loop. Master reset enables every output.

Top module: `outgate_serial_ctrl`

## Requirements
- R1: While idle, a 1 on `sdata` at a rising `sclk` edge is ignored. The receiver stays idle and the enables do not change.
- R2: A 0 sampled at a rising `sclk` edge while idle is a start bit. The next 12 rising edges sample bits D0 to D11 in that order, D0 first.
- R3: Bit Di controls `gated_out[i]`. Indices 0..3 are bank A outputs 0..3, 4..7 are bank B outputs 0..3, 8..10 are bank C outputs 1..3, and 11 is the sync output.
- R4: A bit value of 1 lets `gated_out[i]` follow `gated_in[i]`. A value of 0 holds `gated_out[i]` at logic 0.
- R5: All twelve bits take effect together, and only after the last bit of a frame has been sampled. A frame in progress leaves the outputs on their previous settings.
- R6: `free_out` always equals `free_in`, whatever the frames say. Bit 0 is bank C output 0 and bit 1 is the feedback output.
- R7: While `rst_n` is low, all twelve enables are 1. After reset every gated output runs.
- R8: Every high pulse on a gated output lasts the full high phase of its input clock. Freezing and unfreezing never produce a partial pulse.
- R9: Once a frame has loaded, a 0 at the very next rising `sclk` edge starts a new frame. The later frame's word then replaces the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Free-running serial clock; data sampled on rising edge |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| sdata | input | 1 | Serial data: start bit then 12 enable bits |
| gated_in | input | 12 | Ungated output clocks, one per controllable output |
| free_in | input | 2 | Ungated clocks of the two exempt outputs |
| gated_out | output | 12 | Output clocks after freeze gating |
| free_out | output | 2 | Exempt output clocks, never frozen |

## Verification
The hardest case to reach from the ports is an enable that changes close to an edge of the output clock. A runt pulse could only appear there. The serial clock and the output clocks run at unrelated periods (10 ns and 16 ns), so successive frames that alternate bits between 0 and 1 land their load events at many different phases of the output clocks. A monitor in the bench measures the width of every high pulse on every gated output for the whole run. Atomic loading is checked by sampling the outputs while a frame is still being shifted in. The bench samples after eleven data edges have passed, but before the final bit loads.

// File: rtl/ofz_pkg.sv
package ofz_pkg;
  localparam int NUM_GATED = 12;
  localparam int NUM_FREE  = 2;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {RX_IDLE = 1'b0, RX_SHIFT = 1'b1} rx_state_e;

  // Word held so far with bit idx replaced by b.
  function automatic logic [NUM_GATED-1:0] place_bit(
    input logic [NUM_GATED-1:0] word,
    input int unsigned idx,
    input logic b);
    logic [NUM_GATED-1:0] w;
    w = word;
    w[idx] = b;
    return w;
  endfunction
endpackage

// File: rtl/ofz_serial_rx.sv
module ofz_serial_rx
  import ofz_pkg::*;
#(
  parameter int NBITS = NUM_GATED
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             sdata,
  output logic [NBITS-1:0] ctrl_word,
  output logic [NBITS-1:0] next_word,
  output logic             frame_load,
  output logic             in_frame
);
  localparam int CNT_W = $clog2(NBITS);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NBITS-1:0]  shift_q;

  assign in_frame   = (state_q == RX_SHIFT);
  assign frame_load = in_frame && (cnt_q == CNT_W'(NBITS-1));
  assign next_word  = place_bit(shift_q, 32'(cnt_q), sdata);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      shift_q   <= '1;
      ctrl_word <= '1;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!sdata) state_q <= RX_SHIFT;
        end
        RX_SHIFT: begin
          shift_q <= next_word;
          if (frame_load) begin
            ctrl_word <= next_word;
            state_q   <= RX_IDLE;
            cnt_q     <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ofz_gate_cell.sv
module ofz_gate_cell #(
  parameter int STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic en_async,
  output logic en_applied,
  output logic clk_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], en_async};
  end

  // Taken on the falling edge: the gate only moves while the clock is low.
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) en_applied <= 1'b1;
    else        en_applied <= sync_q[STAGES-1];
  end

  assign clk_out = clk_in & en_applied;
endmodule

// File: rtl/outgate_serial_ctrl.sv
module outgate_serial_ctrl
  import ofz_pkg::*;
(
  input  logic                 sclk,
  input  logic                 rst_n,
  input  logic                 sdata,
  input  logic [NUM_GATED-1:0] gated_in,
  input  logic [NUM_FREE-1:0]  free_in,
  output logic [NUM_GATED-1:0] gated_out,
  output logic [NUM_FREE-1:0]  free_out
);
  logic [NUM_GATED-1:0] ctrl_word;
  logic [NUM_GATED-1:0] next_word;
  logic                 frame_load;
  logic                 in_frame;
  logic [NUM_GATED-1:0] applied_en;

  ofz_serial_rx #(.NBITS(NUM_GATED)) rx_i (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .sdata      (sdata),
    .ctrl_word  (ctrl_word),
    .next_word  (next_word),
    .frame_load (frame_load),
    .in_frame   (in_frame)
  );

  for (genvar g = 0; g < NUM_GATED; g++) begin : g_gate
    ofz_gate_cell #(.STAGES(SYNC_STAGES)) gate_i (
      .clk_in     (gated_in[g]),
      .rst_n      (rst_n),
      .en_async   (ctrl_word[g]),
      .en_applied (applied_en[g]),
      .clk_out    (gated_out[g])
    );
  end

  assign free_out = free_in;
endmodule

// File: rtl/outgate_serial_ctrl_chk.sv
module outgate_serial_ctrl_chk
  import ofz_pkg::*;
(
  input logic                 sclk,
  input logic                 rst_n,
  input logic                 sdata,
  input logic [NUM_GATED-1:0] gated_in,
  input logic [NUM_GATED-1:0] gated_out,
  input logic [NUM_GATED-1:0] ctrl_word,
  input logic [NUM_GATED-1:0] next_word,
  input logic                 frame_load,
  input logic                 in_frame,
  input logic [NUM_GATED-1:0] applied_en
);
  // R1
  idle_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (!in_frame && sdata) |=> !in_frame);

  // R2
  start_bit_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (!in_frame && !sdata) |=> in_frame);

  // R5
  atomic_load_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    frame_load |=> (ctrl_word == $past(next_word)) && !in_frame);

  // R5
  word_stable_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !frame_load |=> $stable(ctrl_word));

  // R7
  reset_enables_chk: assert property (@(posedge sclk)
    $rose(rst_n) |-> (ctrl_word == '1));

  for (genvar g = 0; g < NUM_GATED; g++) begin : g_out
    // R4
    frozen_low_chk: assert property (@(negedge gated_in[g]) disable iff (!rst_n)
      !applied_en[g] |-> !gated_out[g]);
  end
endmodule

bind outgate_serial_ctrl outgate_serial_ctrl_chk chk_i (
  .sclk       (sclk),
  .rst_n      (rst_n),
  .sdata      (sdata),
  .gated_in   (gated_in),
  .gated_out  (gated_out),
  .ctrl_word  (ctrl_word),
  .next_word  (next_word),
  .frame_load (frame_load),
  .in_frame   (in_frame),
  .applied_en (applied_en)
);

// File: tb/outgate_serial_ctrl_tb_top.sv
`timescale 1ns/1ps
module outgate_serial_ctrl_tb_top;
  localparam int NG = 12;
  localparam int HALF = 8;

  logic          sclk = 1'b0;
  logic          src  = 1'b0;
  logic          rst_n = 1'b0;
  logic          sdata = 1'b1;
  logic [NG-1:0] gated_out;
  logic [1:0]    free_out;
  int            checks = 0;
  int            errors = 0;
  int            runts  = 0;
  int            rises  = 0;
  logic [NG-1:0] prev_out = '0;
  time           rise_t [NG];

  always #5 sclk = ~sclk;
  always #HALF src = ~src;

  outgate_serial_ctrl dut_i (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .sdata     (sdata),
    .gated_in  ({NG{src}}),
    .free_in   ({2{src}}),
    .gated_out (gated_out),
    .free_out  (free_out)
  );

  // R8 pulse-width monitor on every gated output
  always @(gated_out) begin
    for (int i = 0; i < NG; i++) begin
      if (gated_out[i] === 1'b1 && prev_out[i] !== 1'b1) begin
        rise_t[i] = $time;
        rises++;
      end else if (gated_out[i] === 1'b0 && prev_out[i] === 1'b1) begin
        if ($time - rise_t[i] != HALF) runts++;
      end
    end
    prev_out = gated_out;
  end

  task automatic chk(input logic ok, input string req, input logic [NG-1:0] act,
                     input logic [NG-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out(input logic [NG-1:0] exp, input string req);
    @(posedge src); #4;
    chk(gated_out == exp, req, gated_out, exp);
    chk(free_out == 2'b11, "R6 high", {10'd0, free_out}, 12'h3);
    @(negedge src); #4;
    chk(gated_out == '0, {req, " low"}, gated_out, '0);
    chk(free_out == 2'b00, "R6 low", {10'd0, free_out}, 12'h0);
  endtask

  task automatic send_frame(input logic [NG-1:0] w);
    @(negedge sclk) sdata = 1'b0;
    for (int i = 0; i < NG; i++) @(negedge sclk) sdata = w[i];
    @(negedge sclk) sdata = 1'b1;
  endtask

  task automatic settle();
    repeat (12) @(posedge src);
  endtask

  task automatic apply_reset();
    @(negedge src); #2 rst_n = 1'b0;
    @(negedge src); #2 rst_n = 1'b1;
  endtask

  task automatic t_reset();
    settle();
    check_out('1, "R7 after reset");
  endtask

  task automatic t_map();
    send_frame(12'hA5C); settle();
    check_out(12'hA5C, "R2 R3 R4 frame A5C");
    send_frame(12'h801); settle();
    check_out(12'h801, "R3 bank A0 and sync only");
  endtask

  task automatic t_idle();
    sdata = 1'b1;
    repeat (40) @(posedge sclk);
    check_out(12'h801, "R1 idle high data");
  endtask

  task automatic t_freeze_all();
    send_frame(12'h000); settle();
    check_out(12'h000, "R4 R6 all frozen");
  endtask

  task automatic t_partial();
    fork
      send_frame(12'h0F3);
      begin
        repeat (12) @(posedge sclk);
        @(posedge src); #4;
        chk(gated_out == 12'h000, "R5 mid frame", gated_out, 12'h000);
      end
    join
    settle();
    check_out(12'h0F3, "R5 after last bit");
  endtask

  task automatic t_back2back();
    logic [NG-1:0] a, b;
    a = 12'h123; b = 12'hFFE;
    @(negedge sclk) sdata = 1'b0;
    for (int i = 0; i < NG; i++) @(negedge sclk) sdata = a[i];
    @(negedge sclk) sdata = 1'b0;
    for (int i = 0; i < NG; i++) @(negedge sclk) sdata = b[i];
    @(negedge sclk) sdata = 1'b1;
    settle();
    check_out(12'hFFE, "R9 back to back");
  endtask

  task automatic t_toggle();
    for (int k = 0; k < 10; k++) begin
      send_frame((k % 2 == 0) ? 12'h555 : 12'hAAA);
      repeat (k + 1) @(posedge sclk);
    end
    settle();
    check_out(12'hAAA, "R8 toggle end state");
  endtask

  task automatic t_reset_mid();
    send_frame(12'h000); settle();
    apply_reset(); settle();
    check_out('1, "R7 reset restores");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge src);
    #2 rst_n = 1'b1;
    t_reset();
    t_map();
    t_idle();
    t_freeze_all();
    t_partial();
    t_back2back();
    t_toggle();
    t_reset_mid();
    checks++;
    if (runts != 0 || rises == 0) begin
      errors++;
      $display("FAIL R8 runt pulses actual=%0d expected=0 (rises=%0d)", runts, rises);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule